// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns phase requests from an I2C byte engine into the SCL waveform and the SDA drive, change and sample points. The engine asks for one of four phases: START, one data bit, repeated START, or STOP. The generator drives the open-drain lines as "pull low" enables and pulses a done strobe when the phase ends. After a START or a data bit it keeps SCL held low, so the bus stays owned between phases. After a STOP it returns to idle with both lines released.

Four separate cycle counts, all in operation-clock cycles, set the timing:
- the whole SCL period;
- the SCL low time;
- the setup time before a repeated START or STOP, which also sets the hold after a START;
- the data setup time from an SDA change to SCL rising.

The SCL high time is the period minus the low time. The high-time counter runs only while SCL is actually seen high, so a target that stretches the clock lengthens the high phase instead of cutting it short. Counts are meant to be changed only while the enable is low. With the enable low the block sits idle with both lines released.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, scl_drive_low, sda_drive_low and all strobes are 0, and req_ready is 1 once run_en is high.
- R2: One cycle after run_en is low, both drive outputs are 0 and req_ready is 0. Requests made while run_en is low are not accepted and cause no phase_done.
- R3: START (req_kind 2'b00, accepted only from idle) pulls SDA low with a change strobe. After eff(rsetup) cycles it pulls SCL low and pulses phase_done in the same cycle. eff(x) is x, or 1 when x is 0.
- R4: In a data bit (req_kind 2'b01, accepted only while the bus is held), SDA takes the requested value with a change strobe exactly eff(dsetup) cycles before SCL is released. req_bit 1 releases SDA and req_bit 0 pulls it low.
- R5: The high time of a data bit is H cycles, with H = eff(period) - eff(low) when that is positive and 1 otherwise. SCL is pulled low again and phase_done pulses H cycles after the release.
- R6: sda_sample_stb pulses floor(H/2)+1 cycles after the SCL release. sample_bit then holds the SDA line level seen while SCL was high.
- R7: Each cycle in which SCL is held low externally after the release delays phase_done and the sample strobe by one cycle.
- R8: A repeated START (req_kind 2'b10) releases SDA, waits eff(low) cycles and releases SCL. After eff(rsetup) high cycles it pulls SDA low, and after another eff(rsetup) cycles it pulls SCL low with phase_done.
- R9: STOP (req_kind 2'b11) pulls SDA low, waits eff(low) cycles and releases SCL. After eff(rsetup) high cycles it releases SDA with phase_done, leaving both lines released and the block idle.
- R10: A count of 0 in any of the four count inputs behaves as a count of 1.
- R11: A request whose kind is not legal in the present state is ignored: a data bit, repeated START or STOP from idle, or a START while held. No line changes and phase_done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Normal operation enable; low forces idle with lines released |
| cfg_period | input | CW | Whole SCL period in cycles |
| cfg_low | input | CW | SCL low time in cycles |
| cfg_rsetup | input | CW | Repeated START / STOP setup and START hold in cycles |
| cfg_dsetup | input | CW | Data setup from SDA change to SCL release in cycles |
| req_valid | input | 1 | Phase request valid |
| req_kind | input | 2 | 00 START, 01 data bit, 10 repeated START, 11 STOP |
| req_bit | input | 1 | Data bit value for a data-bit phase |
| req_ready | output | 1 | Block is between phases and may accept a request |
| scl_in | input | 1 | Observed SCL line level |
| sda_in | input | 1 | Observed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low |
| sda_drive_low | output | 1 | 1 pulls SDA low |
| sda_change_stb | output | 1 | One-cycle pulse when the SDA drive is updated |
| sda_sample_stb | output | 1 | One-cycle pulse when sample_bit is updated |
| sample_bit | output | 1 | SDA level captured mid-high |
| phase_done | output | 1 | One-cycle pulse at the end of a phase |

## Verification
The bench targets these cases:
- An odd high time. A wrong midpoint shifts the sample strobe by one cycle.
- A data setup longer than the low time. A generator without clamping underflows its pre-change count and waits a whole counter wrap.
- All counts zero. A design without the zero-as-one rule stalls or wraps.
- A stretched clock during a read bit, where the target pulls SDA low. A generator that starts its high count at its own release ends the high phase too early and samples the wrong cycle.
- A disable while the bus is held, and requests illegal in the current state. Both must leave the lines alone.

// File: rtl/i2c_bt_pkg.sv
// Package: shared types for the I2C bit timing generator.
// Assumes: phase encodings match the req_kind port of the top module.
package i2c_bt_pkg;

    // Phase kinds requested by the byte engine
    typedef enum logic [1:0] {
        PH_START   = 2'd0,
        PH_BIT     = 2'd1,
        PH_RESTART = 2'd2,
        PH_STOP    = 2'd3
    } phase_e;

    // Sequencer states; each timed state lasts exactly its loaded count
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_HELD   = 4'd1,
        ST_S_HOLD = 4'd2,
        ST_B_PRE  = 4'd3,
        ST_B_SET  = 4'd4,
        ST_B_HIGH = 4'd5,
        ST_L_LOW  = 4'd6,
        ST_R_HIGH = 4'd7,
        ST_R_HOLD = 4'd8,
        ST_P_HIGH = 4'd9
    } state_e;

endpackage

// File: rtl/i2c_bt_calc.sv
// Module: derives effective, never-zero timing counts from the raw inputs.
// Assumes: inputs are quasi-static (changed only while the generator is off).
module i2c_bt_calc #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] low_i,
    input  logic [CW-1:0] rsetup_i,
    input  logic [CW-1:0] dsetup_i,
    output logic [CW-1:0] low_o,
    output logic [CW-1:0] rsetup_o,
    output logic [CW-1:0] dsetup_o,
    output logic [CW-1:0] pre_o,
    output logic [CW-1:0] high_o,
    output logic [CW-1:0] smp_at_o
);
    localparam int          NCFG = 4;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] raw [NCFG];
    logic [CW-1:0] eff [NCFG];

    assign raw[0] = period_i;
    assign raw[1] = low_i;
    assign raw[2] = rsetup_i;
    assign raw[3] = dsetup_i;

    // Zero-as-one clamp, one instance per count input (R10)
    for (genvar g = 0; g < NCFG; g++) begin : g_clamp
        assign eff[g] = (raw[g] == '0) ? ONE : raw[g];
    end

    // High time: period minus low, never below one cycle
    assign high_o   = (eff[0] > eff[1]) ? (eff[0] - eff[1]) : ONE;
    // Low-phase part before the SDA change, never below one cycle
    assign pre_o    = (eff[1] > eff[3]) ? (eff[1] - eff[3]) : ONE;
    // Remaining-count value at which floor(H/2) high cycles have elapsed
    assign smp_at_o = high_o - (high_o >> 1);
    assign low_o    = eff[1];
    assign rsetup_o = eff[2];
    assign dsetup_o = eff[3];

endmodule

// File: rtl/i2c_bt_cnt.sv
// Module: loadable down-counter that times one sequencer state.
// Assumes: load values are never zero; expire marks the last counted cycle.
module i2c_bt_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          en_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o
);
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q;

    // Load on state entry, otherwise count down while enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (en_i && (cnt_q > ONE)) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = en_i && (cnt_q == ONE);

    // R10: a loaded count is never zero, so a state always ends
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q != '0));

    // R7: while not enabled (SCL stretched) the count holds
    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_bt_seq.sv
// Module: phase sequencer; drives SCL/SDA and the strobes from timed states.
// Assumes: the counter is loaded in the cycle a timed state is entered, and
// scl_in reflects the wired-AND SCL line level.
module i2c_bt_seq
    import i2c_bt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en_i,
    input  logic          req_valid_i,
    input  logic [1:0]    req_kind_i,
    input  logic          req_bit_i,
    output logic          req_ready_o,
    input  logic          scl_in_i,
    input  logic          sda_in_i,
    input  logic [CW-1:0] low_i,
    input  logic [CW-1:0] rsetup_i,
    input  logic [CW-1:0] dsetup_i,
    input  logic [CW-1:0] pre_i,
    input  logic [CW-1:0] high_i,
    input  logic [CW-1:0] smp_at_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          expire_i,
    output logic          cnt_load_o,
    output logic [CW-1:0] cnt_val_o,
    output logic          cnt_en_o,
    output logic          scl_low_o,
    output logic          sda_low_o,
    output logic          chg_stb_o,
    output logic          smp_stb_o,
    output logic          smp_bit_o,
    output logic          done_o
);
    state_e st_q, st_nx;
    phase_e kind_in, kind_q;
    logic   bit_q;
    logic   scl_q, sda_q, chg_q, smp_q, sbit_q, done_q;
    logic   scl_nx, sda_nx, chg_nx, smp_nx, done_nx;
    logic   legal, accept, high_state;

    assign kind_in = phase_e'(req_kind_i);

    // Legality of a request in the current resting state (R11)
    assign legal = ((st_q == ST_IDLE) && (kind_in == PH_START)) ||
                   ((st_q == ST_HELD) && (kind_in != PH_START));
    assign accept      = run_en_i && req_valid_i && legal;
    assign req_ready_o = run_en_i && ((st_q == ST_IDLE) || (st_q == ST_HELD));

    // High-phase states count only while SCL is seen high (R7)
    assign high_state = (st_q == ST_B_HIGH) || (st_q == ST_R_HIGH) ||
                        (st_q == ST_P_HIGH);
    assign cnt_en_o   = high_state ? scl_in_i : 1'b1;

    // Next state, counter load and next line/strobe values
    always_comb begin
        st_nx      = st_q;
        cnt_load_o = 1'b0;
        cnt_val_o  = low_i;
        scl_nx     = scl_q;
        sda_nx     = sda_q;
        chg_nx     = 1'b0;
        smp_nx     = 1'b0;
        done_nx    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                scl_nx = 1'b0;
                sda_nx = 1'b0;
                if (accept) begin
                    sda_nx     = 1'b1;
                    chg_nx     = 1'b1;
                    st_nx      = ST_S_HOLD;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = rsetup_i;
                end
            end
            ST_HELD: begin
                if (accept) begin
                    cnt_load_o = 1'b1;
                    unique case (kind_in)
                        PH_BIT: begin
                            st_nx     = ST_B_PRE;
                            cnt_val_o = pre_i;
                        end
                        PH_RESTART: begin
                            sda_nx = 1'b0;
                            chg_nx = 1'b1;
                            st_nx  = ST_L_LOW;
                        end
                        default: begin
                            sda_nx = 1'b1;
                            chg_nx = 1'b1;
                            st_nx  = ST_L_LOW;
                        end
                    endcase
                end
            end
            ST_S_HOLD: begin
                if (expire_i) begin
                    scl_nx  = 1'b1;
                    done_nx = 1'b1;
                    st_nx   = ST_HELD;
                end
            end
            ST_B_PRE: begin
                if (expire_i) begin
                    sda_nx     = !bit_q;
                    chg_nx     = 1'b1;
                    st_nx      = ST_B_SET;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = dsetup_i;
                end
            end
            ST_B_SET: begin
                if (expire_i) begin
                    scl_nx     = 1'b0;
                    st_nx      = ST_B_HIGH;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = high_i;
                end
            end
            ST_B_HIGH: begin
                if (scl_in_i && (cnt_i == smp_at_i)) begin
                    smp_nx = 1'b1;
                end
                if (expire_i) begin
                    scl_nx  = 1'b1;
                    done_nx = 1'b1;
                    st_nx   = ST_HELD;
                end
            end
            ST_L_LOW: begin
                if (expire_i) begin
                    scl_nx     = 1'b0;
                    st_nx      = (kind_q == PH_STOP) ? ST_P_HIGH : ST_R_HIGH;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = rsetup_i;
                end
            end
            ST_R_HIGH: begin
                if (expire_i) begin
                    sda_nx     = 1'b1;
                    chg_nx     = 1'b1;
                    st_nx      = ST_R_HOLD;
                    cnt_load_o = 1'b1;
                    cnt_val_o  = rsetup_i;
                end
            end
            ST_R_HOLD: begin
                if (expire_i) begin
                    scl_nx  = 1'b1;
                    done_nx = 1'b1;
                    st_nx   = ST_HELD;
                end
            end
            ST_P_HIGH: begin
                if (expire_i) begin
                    sda_nx  = 1'b0;
                    chg_nx  = 1'b1;
                    done_nx = 1'b1;
                    st_nx   = ST_IDLE;
                end
            end
            default: begin
                st_nx = ST_IDLE;
            end
        endcase
        if (!run_en_i) begin
            st_nx      = ST_IDLE;
            cnt_load_o = 1'b0;
            scl_nx     = 1'b0;
            sda_nx     = 1'b0;
            chg_nx     = 1'b0;
            smp_nx     = 1'b0;
            done_nx    = 1'b0;
        end
    end

    // State, line drives and strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            scl_q  <= 1'b0;
            sda_q  <= 1'b0;
            chg_q  <= 1'b0;
            smp_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_nx;
            scl_q  <= scl_nx;
            sda_q  <= sda_nx;
            chg_q  <= chg_nx;
            smp_q  <= smp_nx;
            done_q <= done_nx;
        end
    end

    // Request kind and data bit captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= PH_START;
            bit_q  <= 1'b1;
        end else if (accept) begin
            kind_q <= kind_in;
            bit_q  <= req_bit_i;
        end
    end

    // Sampled SDA level, updated only at the mid-high point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sbit_q <= 1'b0;
        end else if (smp_nx) begin
            sbit_q <= sda_in_i;
        end
    end

    assign scl_low_o = scl_q;
    assign sda_low_o = sda_q;
    assign chg_stb_o = chg_q;
    assign smp_stb_o = smp_q;
    assign smp_bit_o = sbit_q;
    assign done_o    = done_q;

    // R2: with the enable low both lines are released next cycle
    p_off_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> (!scl_q && !sda_q && !done_q));

    // R6: a sample is only taken in a cycle where SCL was seen high
    p_sample_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        smp_q |-> $past(scl_in_i));

    // R5: phase done is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R4: the data-bit SDA change happens while SCL is driven low
    p_bit_change_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_q && (st_q == ST_B_SET)) |-> scl_q);

    // R9: the end of a STOP leaves the block idle with lines released
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_P_HIGH) && expire_i) |=> ((st_q == ST_IDLE) && !scl_q && !sda_q));

endmodule

// File: rtl/i2c_bit_timer.sv
// Module: top of the I2C bit timing generator.
// Assumes: count inputs change only while run_en is low; scl_in/sda_in are
// synchronised line levels; the byte engine holds req_valid until req_ready.
module i2c_bit_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_rsetup,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_bit,
    output logic          req_ready,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          sda_change_stb,
    output logic          sda_sample_stb,
    output logic          sample_bit,
    output logic          phase_done
);
    logic [CW-1:0] e_low, e_rs, e_ds, e_pre, e_high, e_smp;
    logic [CW-1:0] cnt, cnt_val;
    logic          cnt_load, cnt_en, expire;

    // Effective counts
    i2c_bt_calc #(.CW(CW)) calc_i (
        .period_i (cfg_period),
        .low_i    (cfg_low),
        .rsetup_i (cfg_rsetup),
        .dsetup_i (cfg_dsetup),
        .low_o    (e_low),
        .rsetup_o (e_rs),
        .dsetup_o (e_ds),
        .pre_o    (e_pre),
        .high_o   (e_high),
        .smp_at_o (e_smp)
    );

    // State timer
    i2c_bt_cnt #(.CW(CW)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .en_i       (cnt_en),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    // Phase sequencer
    i2c_bt_seq #(.CW(CW)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en_i    (run_en),
        .req_valid_i (req_valid),
        .req_kind_i  (req_kind),
        .req_bit_i   (req_bit),
        .req_ready_o (req_ready),
        .scl_in_i    (scl_in),
        .sda_in_i    (sda_in),
        .low_i       (e_low),
        .rsetup_i    (e_rs),
        .dsetup_i    (e_ds),
        .pre_i       (e_pre),
        .high_i      (e_high),
        .smp_at_i    (e_smp),
        .cnt_i       (cnt),
        .expire_i    (expire),
        .cnt_load_o  (cnt_load),
        .cnt_val_o   (cnt_val),
        .cnt_en_o    (cnt_en),
        .scl_low_o   (scl_drive_low),
        .sda_low_o   (sda_drive_low),
        .chg_stb_o   (sda_change_stb),
        .smp_stb_o   (sda_sample_stb),
        .smp_bit_o   (sample_bit),
        .done_o      (phase_done)
    );

endmodule

// File: tb/i2c_bit_timer_tb_top.sv
// Scoreboard bench: the driver queues expected phase timings, the monitor
// measures them from the outputs and compares on each phase_done.
module i2c_bit_timer_tb_top;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_rsetup = '0, cfg_dsetup = '0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_bit = 1'b1;
    logic          req_ready, scl_in, sda_in;
    logic          scl_drive_low, sda_drive_low, sda_change_stb;
    logic          sda_sample_stb, sample_bit, phase_done;
    logic          ext_hold = 1'b0;
    logic          slave_low = 1'b0;
    int            stretch_req = 0;

    int n_tests = 0;
    int n_fail  = 0;
    int p_v = 0, l_v = 0, r_v = 0, d_v = 0;
    string cfg_tag = "";

    typedef struct {
        int    kind;
        int    a, b, c, d;
        string ta, tb, tc;
    } exp_t;
    exp_t exp_q [$];

    always #4 clk = ~clk;

    assign scl_in = !scl_drive_low && !ext_hold;
    assign sda_in = !sda_drive_low && !slave_low;

    i2c_bit_timer #(.CW(CW)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_en         (run_en),
        .cfg_period     (cfg_period),
        .cfg_low        (cfg_low),
        .cfg_rsetup     (cfg_rsetup),
        .cfg_dsetup     (cfg_dsetup),
        .req_valid      (req_valid),
        .req_kind       (req_kind),
        .req_bit        (req_bit),
        .req_ready      (req_ready),
        .scl_in         (scl_in),
        .sda_in         (sda_in),
        .scl_drive_low  (scl_drive_low),
        .sda_drive_low  (sda_drive_low),
        .sda_change_stb (sda_change_stb),
        .sda_sample_stb (sda_sample_stb),
        .sample_bit     (sample_bit),
        .phase_done     (phase_done)
    );

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic string tg(input string t);
        return (cfg_tag != "") ? cfg_tag : t;
    endfunction

    // Target model: holds SCL low for stretch_req cycles after the master releases it
    int hold_left = 0;
    logic hold_prev = 1'b0;
    always @(negedge clk) begin
        if (hold_prev && !scl_drive_low && stretch_req > 0) begin
            hold_left = stretch_req;
            ext_hold  = 1'b1;
        end else if (ext_hold) begin
            hold_left = hold_left - 1;
            if (hold_left <= 0) ext_hold = 1'b0;
        end
        hold_prev = scl_drive_low;
    end

    // Monitor: timestamps events and compares with the queued expectation
    int cyc = 0, t_chg1 = 0, t_chgl = 0, t_rel = 0, t_smp = 0, smp_v = 0;
    bit have_chg = 1'b0;
    logic mon_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sda_change_stb) begin
                if (!have_chg) t_chg1 = cyc;
                t_chgl   = cyc;
                have_chg = 1'b1;
            end
            if (mon_prev && !scl_drive_low) t_rel = cyc;
            if (sda_sample_stb) begin
                t_smp = cyc;
                smp_v = int'(sample_bit);
            end
            if (phase_done) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    case (e.kind)
                        0: begin
                            check(e.ta, cyc - t_chg1, e.a);
                            check(tg("R3 SCL low at done"), int'(scl_drive_low), 1);
                        end
                        1: begin
                            check(e.ta, t_rel - t_chgl, e.a);
                            check(e.tb, cyc - t_rel, e.b);
                            check(e.tc, t_smp - t_rel, e.c);
                            check(tg("R6 sample value"), smp_v, e.d);
                            check(tg("R5 SCL low at done"), int'(scl_drive_low), 1);
                        end
                        2: begin
                            check(e.ta, t_rel - t_chg1, e.a);
                            check(e.tb, t_chgl - t_rel, e.b);
                            check(e.tc, cyc - t_chgl, e.c);
                        end
                        default: begin
                            check(e.ta, t_rel - t_chg1, e.a);
                            check(e.tb, cyc - t_rel, e.b);
                            check(tg("R9 lines released"),
                                  int'(scl_drive_low) + int'(sda_drive_low), 0);
                        end
                    endcase
                end
                have_chg = 1'b0;
            end
        end
        mon_prev = scl_drive_low;
    end

    // Driver: queue the expectation, issue the request, wait for done
    task automatic run_phase(input int kind, input bit b, input int stretch, input bit slv);
        exp_t e;
        int hv;
        hv = (eff(p_v) > eff(l_v)) ? eff(p_v) - eff(l_v) : 1;
        e.kind = kind; e.a = 0; e.b = 0; e.c = 0; e.d = 0;
        e.ta = ""; e.tb = ""; e.tc = "";
        case (kind)
            0: begin e.a = eff(r_v); e.ta = tg("R3 START hold"); end
            1: begin
                e.a = eff(d_v);              e.ta = tg("R4 data setup");
                e.b = hv + stretch;          e.tb = tg(stretch > 0 ? "R7 stretched high" : "R5 high time");
                e.c = hv / 2 + 1 + stretch;  e.tc = tg(stretch > 0 ? "R7 stretched sample" : "R6 sample point");
                e.d = (b && !slv) ? 1 : 0;
            end
            2: begin
                e.a = eff(l_v); e.ta = tg("R8 restart low");
                e.b = eff(r_v); e.tb = tg("R8 restart setup");
                e.c = eff(r_v); e.tc = tg("R8 restart hold");
            end
            default: begin
                e.a = eff(l_v); e.ta = tg("R9 stop low");
                e.b = eff(r_v); e.tb = tg("R9 stop setup");
            end
        endcase
        exp_q.push_back(e);
        stretch_req = stretch;
        slave_low   = slv;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_bit   = b;
        @(negedge clk);
        req_valid = 1'b0;
        do @(negedge clk); while (!phase_done);
        stretch_req = 0;
        slave_low   = 1'b0;
    endtask

    task automatic set_cfg(input int p, input int l, input int r, input int d);
        @(negedge clk);
        run_en = 1'b0;
        p_v = p; l_v = l; r_v = r; d_v = d;
        cfg_period = CW'(p); cfg_low = CW'(l); cfg_rsetup = CW'(r); cfg_dsetup = CW'(d);
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Main sequence
    initial begin
        int done_seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 scl released", int'(scl_drive_low), 0);
        check("R1 sda released", int'(sda_drive_low), 0);
        check("R1 strobes idle", int'(sda_change_stb) + int'(sda_sample_stb) + int'(phase_done), 0);
        check("R1 ready", int'(req_ready), 1);

        // Nominal ratios: period 40, low 20, setup 20, data setup 2
        set_cfg(40, 20, 20, 2);
        run_phase(0, 1'b0, 0, 1'b0);
        run_phase(1, 1'b0, 0, 1'b0);
        run_phase(1, 1'b1, 0, 1'b0);
        run_phase(1, 1'b1, 3, 1'b1);
        run_phase(2, 1'b0, 0, 1'b0);
        run_phase(1, 1'b1, 0, 1'b0);
        run_phase(3, 1'b0, 0, 1'b0);

        // R11: a data bit from idle is ignored
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1; req_bit = 1'b0;
        done_seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            done_seen += int'(phase_done);
            check("R11 lines unchanged", int'(scl_drive_low) + int'(sda_drive_low), 0);
        end
        check("R11 no done", done_seen, 0);
        req_valid = 1'b0;

        // Odd high time (13) and data setup longer than low time
        set_cfg(25, 12, 7, 3);
        run_phase(0, 1'b0, 0, 1'b0);
        run_phase(1, 1'b1, 0, 1'b0);
        run_phase(1, 1'b0, 5, 1'b0);
        run_phase(3, 1'b0, 0, 1'b0);
        set_cfg(10, 3, 4, 5);
        run_phase(0, 1'b0, 0, 1'b0);
        run_phase(1, 1'b1, 0, 1'b0);
        run_phase(3, 1'b0, 0, 1'b0);

        // R10: all counts zero behave as one
        cfg_tag = "R10";
        set_cfg(0, 0, 0, 0);
        run_phase(0, 1'b0, 0, 1'b0);
        run_phase(1, 1'b1, 0, 1'b0);
        run_phase(1, 1'b0, 0, 1'b0);
        run_phase(2, 1'b0, 0, 1'b0);
        run_phase(3, 1'b0, 0, 1'b0);
        cfg_tag = "";

        // R2: disable while the bus is held, then try a START while off
        set_cfg(40, 20, 20, 2);
        run_phase(0, 1'b0, 0, 1'b0);
        check("R2 held before disable", int'(scl_drive_low), 1);
        run_en = 1'b0;
        @(negedge clk);
        check("R2 lines released", int'(scl_drive_low) + int'(sda_drive_low), 0);
        check("R2 not ready", int'(req_ready), 0);
        req_valid = 1'b1; req_kind = 2'd0;
        done_seen = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            done_seen += int'(phase_done) + int'(sda_drive_low) + int'(sda_change_stb);
        end
        check("R2 request ignored", done_seen, 0);
        req_valid = 1'b0;
        @(negedge clk);
        run_en = 1'b1;
        @(negedge clk);
        check("R2 ready again", int'(req_ready), 1);
        check("R1 queue drained", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule